// File: doc/BRIEF.md
# Page Write Buffer and Commit Unit

This block sits behind the serial front end of a small byte-addressed non-volatile memory. It gathers the data bytes of one write transaction into a 16-entry page latch and writes them into the memory array only when the transaction closes with a Stop. The transaction opens with a start address. Each received byte lands in the latch entry that the low four address bits select. Those four bits then advance by one and wrap inside the page, and the upper address bits do not change. When a transaction carries more than 16 bytes, the later bytes replace earlier entries of the same page.

On Stop, if at least one byte was latched, the unit starts a self-timed write cycle. The cycle length is a parameter in clock cycles, and busy stays high for the whole cycle. During the first 16 cycles of that window, the unit steps through the latch entries in index order and issues one array write per received entry. Entries that were never filled are skipped. The unit samples the write-protect level once, at Stop. If that level is high and the page lies in the upper half of the address space, the writes are suppressed. A repeated Start (abort) empties the latch, and no write cycle follows. While busy is high, the unit ignores every transaction input.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, busy and mem_we are low.
- R2: A byte received k bytes after a start address A is committed to address {A[9:4], (A[3:0]+k) mod 16}. The upper six address bits never change within a transaction.
- R3: When more than 16 bytes are received, the byte numbered k (counting from 0) overwrites the byte numbered k-16. Each page address is written at most once per commit, with the last value received for it.
- R4: No array write happens before Stop. A Stop that follows an abort pulse starts no write cycle and writes nothing.
- R5: A Stop with at least one latched byte raises busy on the next clock edge. Busy then stays high for exactly WCYC cycles (at least 16), and mem_we is high only while busy is high.
- R6: Only the entries that received a byte are written. Entry i is written in busy cycle i, counting from 0, and the latch is empty when busy falls.
- R7: If write-protect is high at Stop, pages with address bit 9 set are not written, but the write cycle still runs its full length. Pages with bit 9 clear are written whatever the protect level.
- R8: Changes of the write-protect level during busy do not affect the commit in progress.
- R9: Start address, byte, Stop and abort inputs that arrive while busy is high have no effect.
- R10: A Stop with no latched byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Pulse: opens a transaction at start_addr and empties the latch |
| start_addr | input | 10 | Start address of the transaction |
| byte_strobe | input | 1 | Pulse: one received data byte |
| byte_data | input | 8 | Data of the received byte |
| stop_pulse | input | 1 | Pulse: Stop condition seen |
| abort_pulse | input | 1 | Pulse: repeated Start seen, latched bytes discarded |
| wp_level | input | 1 | Write-protect level for the upper half of the array |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 10 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | High for the whole self-timed write cycle |

## Verification
The bench goes after the page wrap, where a design that carried the increment into bit 4 would write into the next page. It also covers the 17-to-20-byte overwrite, where a wrong design would write an address twice or keep the stale byte. Sparse fills show up a design without per-entry valid bits, because it would write zeros into untouched entries. Write-protect is toggled both ways during busy, which exposes a design that reads the live level instead of the value sampled at Stop. Abort, an empty Stop, and a full transaction sent during busy each catch a design that starts a phantom cycle or lets latched bytes leak into a later commit.

// File: rtl/pcu_pkg.sv
// Shared types and helpers for the page write buffer and commit unit.
package pcu_pkg;

    // Commit sequencer state: waiting for a Stop, or running the timed cycle.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Larger of two integers, used to derive the effective cycle length.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcu_page_latch.sv
// Page latch: holds up to 2**PAGE_W data bytes with per-entry valid bits,
// the fixed page base and the wrapping in-page write pointer.
// Assumes: addr_load takes priority over byte_strobe in the same cycle;
// accept_en is low while a commit runs; discard empties every entry.
module pcu_page_latch #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept_en,
    input  logic                       addr_load,
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic                       byte_strobe,
    input  logic [DATA_W-1:0]          byte_data,
    input  logic                       discard,
    input  logic [PAGE_W-1:0]          rd_idx,
    output logic [ADDR_W-PAGE_W-1:0]   page_base,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       any_valid
);
    localparam int ENTRIES = 1 << PAGE_W;
    localparam int BASE_W  = ADDR_W - PAGE_W;

    logic [DATA_W-1:0]  ent_data [ENTRIES];
    logic [ENTRIES-1:0] ent_vld;
    logic [PAGE_W-1:0]  wr_ptr;
    logic               do_load;
    logic               do_byte;

    assign do_load = accept_en && addr_load;
    assign do_byte = accept_en && byte_strobe && !addr_load;

    // Page base and in-page pointer: load on a new transaction, step per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_base <= '0;
            wr_ptr    <= '0;
        end else if (do_load) begin
            page_base <= start_addr[ADDR_W-1:PAGE_W];
            wr_ptr    <= start_addr[PAGE_W-1:0];
        end else if (do_byte) begin
            wr_ptr    <= wr_ptr + 1'b1;
        end
    end

    // Entry storage: write the addressed entry, empty all on load or discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_data[i] <= '0;
        end else if (discard || do_load) begin
            ent_vld <= '0;
        end else if (do_byte) begin
            ent_vld[wr_ptr]  <= 1'b1;
            ent_data[wr_ptr] <= byte_data;
        end
    end

    // Read side for the commit scan.
    always_comb begin
        rd_data   = ent_data[rd_idx];
        rd_valid  = ent_vld[rd_idx];
        any_valid = |ent_vld;
    end

    // The page base must not move while the latch is closed to input.
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_en |=> $stable(page_base)); // R9

    logic unused_base_w;
    assign unused_base_w = (BASE_W > 0);
endmodule

// File: rtl/pcu_commit_seq.sv
// Commit sequencer: on Stop with a non-empty latch, runs a self-timed write
// cycle of CYC_EFF clocks, holds busy, samples write-protect once and scans
// the latch entries in the first 2**PAGE_W cycles.
// Assumes: stop_pulse is a single-cycle pulse; WCYC below the page size is
// stretched to the page size so every entry gets a scan slot.
module pcu_commit_seq
    import pcu_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int WCYC   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_pulse,
    input  logic              any_valid,
    input  logic              wp_level,
    output logic              busy,
    output logic              scan_act,
    output logic [PAGE_W-1:0] scan_idx,
    output logic              wp_held,
    output logic              done
);
    localparam int ENTRIES = 1 << PAGE_W;
    localparam int CYC_EFF = max_int(WCYC, ENTRIES);
    localparam int CNT_W   = $clog2(CYC_EFF + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    assign busy     = (state == SEQ_RUN);
    assign done     = busy && (cnt == CNT_W'(CYC_EFF - 1));
    assign scan_act = busy && (cnt < CNT_W'(ENTRIES));
    assign scan_idx = cnt[PAGE_W-1:0];

    // Cycle timer: start on Stop with data, count, return to idle at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            wp_held <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (stop_pulse && any_valid) begin
                        state   <= SEQ_RUN;
                        cnt     <= '0;
                        wp_held <= wp_level;
                    end
                end
                SEQ_RUN: begin
                    if (done) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // A write cycle only ever begins right after a Stop.
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse)); // R4

    // The sampled protect level stays put for the whole cycle.
    AST_WP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(wp_held)); // R8
endmodule

// File: rtl/pcu_wp_gate.sv
// Write gate: turns a scan slot into an array write when the entry holds a
// received byte and the page is not protected. PROTECT_UPPER selects whether
// the upper half of the address space honours the protect level at all.
// Assumes: page_msb is the top address bit of the page being committed.
module pcu_wp_gate #(
    parameter bit PROTECT_UPPER = 1'b1
) (
    input  logic scan_act,
    input  logic entry_valid,
    input  logic wp_held,
    input  logic page_msb,
    output logic write_en
);
    generate
        if (PROTECT_UPPER) begin : g_prot
            // Block writes to the upper half when protection was sampled high.
            always_comb write_en = scan_act && entry_valid && !(wp_held && page_msb);
        end else begin : g_open
            // Protection disabled: every received entry is written.
            logic unused_prot;
            assign unused_prot = wp_held ^ page_msb;
            always_comb write_en = scan_act && entry_valid;
        end
    endgenerate
endmodule

// File: rtl/page_commit_unit.sv
// Page write buffer and commit unit (top). Collects one transaction's bytes
// into a page latch and, on Stop, commits them to the array through a
// self-timed write cycle, honouring upper-half write protection.
// Assumes: control inputs are single-cycle pulses from the serial front end;
// the array accepts one write per clock on the mem_* port.
module page_commit_unit #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4,
    parameter int WCYC   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_strobe,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_pulse,
    input  logic              abort_pulse,
    input  logic              wp_level,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic              seq_busy;
    logic              scan_act;
    logic [PAGE_W-1:0] scan_idx;
    logic              wp_held;
    logic              seq_done;
    logic [BASE_W-1:0] page_base;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              any_valid;
    logic              discard;

    // Latch is emptied by an abort while idle or by the end of a commit.
    assign discard = (abort_pulse && !seq_busy) || seq_done;

    pcu_page_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_en  (!seq_busy),
        .addr_load  (addr_load),
        .start_addr (start_addr),
        .byte_strobe(byte_strobe),
        .byte_data  (byte_data),
        .discard    (discard),
        .rd_idx     (scan_idx),
        .page_base  (page_base),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .any_valid  (any_valid)
    );

    pcu_commit_seq #(
        .PAGE_W(PAGE_W), .WCYC(WCYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_pulse(stop_pulse),
        .any_valid (any_valid),
        .wp_level  (wp_level),
        .busy      (seq_busy),
        .scan_act  (scan_act),
        .scan_idx  (scan_idx),
        .wp_held   (wp_held),
        .done      (seq_done)
    );

    pcu_wp_gate #(
        .PROTECT_UPPER(1'b1)
    ) u_gate (
        .scan_act   (scan_act),
        .entry_valid(rd_valid),
        .wp_held    (wp_held),
        .page_msb   (page_base[BASE_W-1]),
        .write_en   (mem_we)
    );

    // Array port: page base with the scanned entry index, data from the latch.
    always_comb begin
        mem_addr  = {page_base, scan_idx};
        mem_wdata = rd_data;
        busy      = seq_busy;
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5

    AST_PROT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_held) |-> !mem_addr[ADDR_W-1]); // R7

    AST_LATCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !any_valid); // R6
endmodule

// File: tb/tb_page_commit_unit.sv
module tb_page_commit_unit;
    localparam int WCYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [9:0] start_addr = '0;
    logic       byte_strobe = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_pulse = 1'b0;
    logic       abort_pulse = 1'b0;
    logic       wp_level = 1'b0;
    logic       mem_we;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int busy_cyc = 0;
    int dup_hits = 0;
    logic [7:0] tbmem [1024];
    bit         hit [1024];

    page_commit_unit #(.WCYC(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_strobe(byte_strobe), .byte_data(byte_data), .stop_pulse(stop_pulse),
        .abort_pulse(abort_pulse), .wp_level(wp_level), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Array model and per-cycle write rules (R5, R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (hit[mem_addr]) dup_hits++;
                hit[mem_addr]    = 1'b1;
                tbmem[mem_addr]  = mem_wdata;
                wcount++;
                check(busy, "R5 write outside busy", 0, 1);
                check(int'(mem_addr[3:0]) == busy_cyc, "R6 slot of entry", busy_cyc, int'(mem_addr[3:0]));
            end
            if (busy) busy_cyc++;
            else begin
                busy_cyc = 0;
                for (int i = 0; i < 1024; i++) hit[i] = 1'b0;
            end
        end
    end

    task automatic pulse_load(input logic [9:0] a);
        @(negedge clk); addr_load = 1'b1; start_addr = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic send_bytes(input int n, input logic [7:0] d0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_strobe = 1'b1; byte_data = d0 + 8'(i);
        end
        @(negedge clk); byte_strobe = 1'b0;
    endtask

    // Issues Stop and returns the number of cycles busy was seen high.
    task automatic stop_and_wait(output int len);
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(mem_we == 1'b0, "R1 mem_we after reset", mem_we, 0);
    endtask

    task automatic t_single;
        int len, w0;
        w0 = wcount;
        pulse_load(10'h045);
        send_bytes(1, 8'hA5);
        repeat (3) @(negedge clk);
        check(wcount == w0, "R4 no write before stop", wcount - w0, 0);
        stop_and_wait(len);
        check(len == WCYC, "R5 busy length", len, WCYC);
        check(tbmem[10'h045] == 8'hA5, "R2 single byte", tbmem[10'h045], 8'hA5);
        check(wcount - w0 == 1, "R6 single write count", wcount - w0, 1);
    endtask

    task automatic t_page_wrap;
        int len, w0;
        w0 = wcount;
        pulse_load(10'h10C);
        send_bytes(5, 8'h30);
        stop_and_wait(len);
        check(tbmem[10'h10F] == 8'h33, "R2 last before wrap", tbmem[10'h10F], 8'h33);
        check(tbmem[10'h100] == 8'h34, "R2 wrap to page start", tbmem[10'h100], 8'h34);
        check(tbmem[10'h110] == 8'h00, "R2 next page untouched", tbmem[10'h110], 0);
        check(wcount - w0 == 5, "R6 sparse count", wcount - w0, 5);
    endtask

    task automatic t_overflow;
        int len, w0;
        w0 = wcount;
        dup_hits = 0;
        pulse_load(10'h230);
        send_bytes(20, 8'h50);
        stop_and_wait(len);
        check(wcount - w0 == 16, "R3 one write per entry", wcount - w0, 16);
        check(dup_hits == 0, "R3 no duplicate address", dup_hits, 0);
        check(tbmem[10'h230] == 8'h60, "R3 entry 0 overwritten", tbmem[10'h230], 8'h60);
        check(tbmem[10'h233] == 8'h63, "R3 entry 3 overwritten", tbmem[10'h233], 8'h63);
        check(tbmem[10'h234] == 8'h54, "R3 entry 4 kept", tbmem[10'h234], 8'h54);
    endtask

    task automatic t_protect;
        int len, w0;
        wp_level = 1'b1;
        w0 = wcount;
        pulse_load(10'h300);
        send_bytes(3, 8'h71);
        stop_and_wait(len);
        check(wcount == w0, "R7 upper half blocked", wcount - w0, 0);
        check(tbmem[10'h300] == 8'h00, "R7 upper data unchanged", tbmem[10'h300], 0);
        check(len == WCYC, "R7 cycle still runs", len, WCYC);
        pulse_load(10'h1F0);
        send_bytes(2, 8'h81);
        stop_and_wait(len);
        check(tbmem[10'h1F1] == 8'h82, "R7 lower half writable", tbmem[10'h1F1], 8'h82);
        wp_level = 1'b0;
    endtask

    task automatic t_wp_mid;
        int w0;
        // Sampled low, raised during busy: write proceeds.
        wp_level = 1'b0;
        pulse_load(10'h250);
        send_bytes(1, 8'h9C);
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0; wp_level = 1'b1;
        while (busy) @(negedge clk);
        check(tbmem[10'h250] == 8'h9C, "R8 late raise ignored", tbmem[10'h250], 8'h9C);
        // Sampled high, dropped during busy: write stays blocked.
        w0 = wcount;
        pulse_load(10'h260);
        send_bytes(1, 8'hD2);
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0; wp_level = 1'b0;
        while (busy) @(negedge clk);
        check(wcount == w0 && tbmem[10'h260] == 8'h00, "R8 late drop ignored", tbmem[10'h260], 0);
    endtask

    task automatic t_abort_empty;
        int len, w0;
        w0 = wcount;
        pulse_load(10'h080);
        send_bytes(4, 8'hE0);
        @(negedge clk); abort_pulse = 1'b1;
        @(negedge clk); abort_pulse = 1'b0;
        stop_and_wait(len);
        check(len == 0 && wcount == w0, "R4 abort discards", len, 0);
        pulse_load(10'h090);
        stop_and_wait(len);
        check(len == 0, "R10 empty stop", len, 0);
    endtask

    task automatic t_busy_ignore;
        int len, w0;
        pulse_load(10'h020);
        send_bytes(1, 8'h11);
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
        // Full transaction attempt while busy.
        pulse_load(10'h3C0);
        send_bytes(2, 8'hBB);
        @(negedge clk); stop_pulse = 1'b1;
        @(negedge clk); stop_pulse = 1'b0;
        while (busy) @(negedge clk);
        w0 = wcount;
        stop_and_wait(len);
        check(len == 0 && wcount == w0, "R9 busy input ignored", len, 0);
        check(tbmem[10'h3C0] == 8'h00 && tbmem[10'h020] == 8'h11, "R9 memory after busy input",
              tbmem[10'h3C0], 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin tbmem[i] = 8'h00; hit[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_page_wrap();
        t_overflow();
        t_protect();
        t_wp_mid();
        t_abort_empty();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule